// File: doc/BRIEF.md
# Envelope Clip Gain with Local-Minimum Peak Search

This block is the entry stage of a peak-windowing crest factor reducer. Each complex sample (signed I and Q) arrives with a valid strobe. The block forms the envelope magnitude as the integer square root of I² + Q² and compares it with a programmable threshold. When the envelope is above the threshold, the clip gain is the threshold divided by the envelope. Otherwise the gain is exactly unity. Gains are unsigned fixed point with FRAC fraction bits, so unity is `2^FRAC`.

A peak search then looks at the gain sequence through a three-sample window. A gain sample is retained only if it is a local minimum; every other sample is replaced by unity. The block emits the drive signal for a downstream window filter, which is unity minus the retained gain. Each excursion above the threshold therefore produces a single impulse instead of a run of clipped samples.

Samples arrive once every SLOT clocks. The square root and the divider are each iterative and finish inside one slot. The decision for a sample can only be made once its successor's gain is known. Together these give a fixed latency of LATENCY = 3·SLOT clocks from a sample's strobe to its output strobe. LATENCY is exported as a parameter so that downstream logic can match the delay.

Top module: `cfr_clip_peak`

## Requirements
- R1: While reset is applied, and after it is released with no sample yet processed, `out_valid` is 0 and `out_v` is 0.
- R2: The envelope is e = floor(sqrt(I² + Q²)), with I and Q read as signed DW-bit values. If e ≤ th, the gain is exactly unity (`2^FRAC`).
- R3: If e > th, the gain is g = floor(th·2^FRAC / e). When that sample is a local minimum, `out_v` = 2^FRAC − g.
- R4: A gain sample g(n) is a local minimum when g(n) < g(n−1) and g(n) ≤ g(n+1). The predecessor of the first sample after reset is taken as unity.
- R5: In a run of equal clipped gains that is preceded by a larger gain, only the first sample of the run yields a nonzero `out_v`.
- R6: A sample that is not a local minimum yields `out_v` = 0.
- R7: `out_valid` is a one-cycle pulse. `out_v` holds its value between pulses. The result for sample n appears exactly LATENCY = 3·SLOT clocks after sample n's strobe, provided strobes arrive every SLOT clocks. Every sample except the most recent one yields exactly one output.
- R8: If th is at or above the largest possible envelope, floor(sqrt(2)·2^(DW−1)), every output is 0.
- R9: The threshold is captured with its sample's strobe. A change of `th` after the strobe does not affect that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe, asserted once every SLOT clocks |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| th | input | DW | Clipping threshold, unsigned magnitude |
| out_valid | output | 1 | Drive output strobe |
| out_v | output | FRAC+1 | Filter drive, unity minus retained gain, unsigned fixed point |

## Verification
The bench builds the block with DW = 6, FRAC = 15 and SLOT = 4. With this small sample width, every one of the 4096 I/Q pairs can be applied at each of several thresholds. That covers zero, mid-range values, the exact full-scale envelope of 45 and the largest code. Every square-root and division result is compared against arithmetic in the bench, and the sweep order produces many rising, falling and flat gain runs for the peak search. Directed sequences add a flat run of equal clipped gains and a threshold change one clock after a strobe.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    // integer ceiling division used to spread iterations across a slot
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/cfr_env_sqrt.sv
// Envelope magnitude: integer square root of I^2+Q^2, computed in SLOT cycles
module cfr_env_sqrt #(
    parameter int DW   = 12,
    parameter int SLOT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 done,
    output logic [DW-1:0]        env
);
    localparam int K   = cfr_pkg::ceil_div(DW, SLOT);
    localparam int STW = $clog2(DW + 1);
    localparam int CW  = $clog2(SLOT + 1);

    typedef struct packed {
        logic [2*DW-1:0] rad;
        logic [DW-1:0]   rem;
        logic [DW-1:0]   root;
        logic [STW-1:0]  stp;
        logic [CW-1:0]   cnt;
        logic            busy;
        logic            done;
    } sq_st_t;

    sq_st_t sq_d, sq_q;

    logic [DW-1:0]   abs_i, abs_q;
    logic [2*DW-1:0] power;

    always_comb begin
        abs_i = in_i[DW-1] ? DW'(-in_i) : DW'(in_i);
        abs_q = in_q[DW-1] ? DW'(-in_q) : DW'(in_q);
        power = (2*DW)'(abs_i) * (2*DW)'(abs_i) + (2*DW)'(abs_q) * (2*DW)'(abs_q);
    end

    logic [2*DW-1:0] r;
    logic [DW-1:0]   m;
    logic [DW-1:0]   t;
    logic [STW-1:0]  s;
    logic [DW+1:0]   w;
    logic [DW+1:0]   trial;
    logic [CW-1:0]   left;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        r     = start ? power : sq_q.rad;
        m     = start ? '0 : sq_q.rem;
        t     = start ? '0 : sq_q.root;
        s     = start ? '0 : sq_q.stp;
        w     = '0;
        trial = '0;
        left  = '0;
        if (start || sq_q.busy) begin
            for (int k = 0; k < K; k++) begin
                if (s < STW'(DW)) begin
                    w     = {m, r[2*DW-1 -: 2]};
                    r     = r << 2;
                    trial = {t, 2'b01};
                    if (w >= trial) begin
                        w = w - trial;
                        t = {t[DW-2:0], 1'b1};
                    end else begin
                        t = {t[DW-2:0], 1'b0};
                    end
                    m = w[DW-1:0];
                    s = s + 1'b1;
                end
            end
            left      = start ? CW'(SLOT - 1) : sq_q.cnt - 1'b1;
            sq_d.rad  = r;
            sq_d.rem  = m;
            sq_d.root = t;
            sq_d.stp  = s;
            sq_d.cnt  = left;
            sq_d.busy = (left != '0);
            sq_d.done = (left == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign done = sq_q.done;
    assign env  = sq_q.root;

endmodule

// File: rtl/cfr_clip_div.sv
// Clip gain: th/env in unsigned Q1.FRAC when env>th, unity otherwise; SLOT cycles
module cfr_clip_div #(
    parameter int MW   = 12,
    parameter int FRAC = 15,
    parameter int SLOT = 4,
    localparam int GW  = FRAC + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] env,
    input  logic [MW-1:0] th,
    output logic          done,
    output logic [GW-1:0] gain
);
    localparam int K  = cfr_pkg::ceil_div(FRAC, SLOT);
    localparam int SW = $clog2(FRAC + 1);
    localparam int CW = $clog2(SLOT + 1);
    localparam logic [GW-1:0] UNITY = {1'b1, {FRAC{1'b0}}};

    typedef struct packed {
        logic [MW-1:0]   rem;
        logic [MW-1:0]   den;
        logic [FRAC-1:0] quo;
        logic [SW-1:0]   stp;
        logic [CW-1:0]   cnt;
        logic            clip;
        logic            busy;
        logic            done;
        logic [GW-1:0]   gain;
    } dv_st_t;

    dv_st_t dv_d, dv_q;

    logic            c;
    logic [MW-1:0]   dn;
    logic [MW-1:0]   rm;
    logic [FRAC-1:0] qo;
    logic [SW-1:0]   s;
    logic [MW:0]     w;
    logic [CW-1:0]   left;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        c    = start ? (env > th) : dv_q.clip;
        dn   = start ? env : dv_q.den;
        rm   = start ? th : dv_q.rem;
        qo   = start ? '0 : dv_q.quo;
        s    = start ? '0 : dv_q.stp;
        w    = '0;
        left = '0;
        if (start || dv_q.busy) begin
            for (int k = 0; k < K; k++) begin
                if (s < SW'(FRAC)) begin
                    w = {rm, 1'b0};
                    if (w >= {1'b0, dn}) begin
                        w  = w - {1'b0, dn};
                        qo = {qo[FRAC-2:0], 1'b1};
                    end else begin
                        qo = {qo[FRAC-2:0], 1'b0};
                    end
                    rm = w[MW-1:0];
                    s  = s + 1'b1;
                end
            end
            left      = start ? CW'(SLOT - 1) : dv_q.cnt - 1'b1;
            dv_d.rem  = rm;
            dv_d.den  = dn;
            dv_d.quo  = qo;
            dv_d.stp  = s;
            dv_d.clip = c;
            dv_d.cnt  = left;
            dv_d.busy = (left != '0);
            if (left == '0) begin
                dv_d.done = 1'b1;
                dv_d.gain = c ? {1'b0, qo} : UNITY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q      <= '0;
            dv_q.gain <= UNITY;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign done = dv_q.done;
    assign gain = dv_q.gain;

endmodule

// File: rtl/cfr_peak_pick.sv
// Three-sample local-minimum search; emits unity minus retained gain
module cfr_peak_pick #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [GW-1:0] gain,
    output logic          out_valid,
    output logic [GW-1:0] out_v
);
    localparam logic [GW-1:0] UNITY = {1'b1, {(GW-1){1'b0}}};

    typedef struct packed {
        logic [GW-1:0] prev;
        logic [GW-1:0] mid;
        logic          primed;
        logic          ov;
        logic [GW-1:0] v;
    } pk_st_t;

    pk_st_t pk_d, pk_q;
    logic          is_min;
    logic [GW-1:0] kept;

    always_comb begin
        pk_d    = pk_q;
        pk_d.ov = 1'b0;
        is_min  = (pk_q.mid < pk_q.prev) && (pk_q.mid <= gain);
        kept    = is_min ? pk_q.mid : UNITY;
        if (in_valid) begin
            if (pk_q.primed) begin
                pk_d.ov = 1'b1;
                pk_d.v  = UNITY - kept;
            end
            pk_d.prev   = pk_q.mid;
            pk_d.mid    = gain;
            pk_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q      <= '0;
            pk_q.prev <= UNITY;
            pk_q.mid  <= UNITY;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign out_valid = pk_q.ov;
    assign out_v     = pk_q.v;

endmodule

// File: rtl/cfr_clip_peak.sv
// Top: envelope, clip gain and peak search, fixed latency LATENCY clocks
module cfr_clip_peak #(
    parameter int DW       = 12,
    parameter int FRAC     = 15,
    parameter int SLOT     = 4,
    localparam int GW      = FRAC + 1,
    localparam int LATENCY = 3 * SLOT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [DW-1:0]        th,
    output logic                 out_valid,
    output logic [GW-1:0]        out_v
);
    typedef struct packed {
        logic [DW-1:0] th;
    } top_st_t;

    top_st_t top_d, top_q;

    always_comb begin
        top_d = top_q;
        if (in_valid) begin
            top_d.th = th;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    logic          env_done;
    logic [DW-1:0] env;
    logic          gain_done;
    logic [GW-1:0] gain;

    cfr_env_sqrt #(
        .DW   (DW),
        .SLOT (SLOT)
    ) u_sqrt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (in_valid),
        .in_i  (in_i),
        .in_q  (in_q),
        .done  (env_done),
        .env   (env)
    );

    cfr_clip_div #(
        .MW   (DW),
        .FRAC (FRAC),
        .SLOT (SLOT)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (env_done),
        .env   (env),
        .th    (top_q.th),
        .done  (gain_done),
        .gain  (gain)
    );

    cfr_peak_pick #(
        .GW (GW)
    ) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (gain_done),
        .gain      (gain),
        .out_valid (out_valid),
        .out_v     (out_v)
    );

endmodule

// File: rtl/cfr_clip_peak_chk.sv
module cfr_clip_peak_chk #(
    parameter int SLOT = 4,
    parameter int FRAC = 15,
    localparam int GW  = FRAC + 1,
    localparam int LAT = 3 * SLOT
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [GW-1:0] out_v
);
    localparam logic [GW-1:0] UNITY = {1'b1, {FRAC{1'b0}}};

    logic [LAT:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[LAT-1:0], in_valid};
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hist_q[LAT]);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_v));

    // R3
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_v <= UNITY));

endmodule

bind cfr_clip_peak cfr_clip_peak_chk #(
    .SLOT (SLOT),
    .FRAC (FRAC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_v     (out_v)
);

// File: tb/cfr_clip_peak_test.sv
`timescale 1ns/1ps
module cfr_clip_peak_test;
    localparam int DW    = 6;
    localparam int FRAC  = 15;
    localparam int SLOT  = 4;
    localparam int GW    = FRAC + 1;
    localparam int LAT   = 3 * SLOT;
    localparam int UNITY = 1 << FRAC;
    localparam int NMAX  = 32768;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic [DW-1:0]        th = '0;
    logic                 out_valid;
    logic [GW-1:0]        out_v;

    always #2 clk = ~clk;

    cfr_clip_peak #(.DW(DW), .FRAC(FRAC), .SLOT(SLOT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i),
        .in_q(in_q), .th(th), .out_valid(out_valid), .out_v(out_v)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    exp_arr  [0:NMAX-1];
    int    edge_arr [0:NMAX-1];
    string tag_arr  [0:NMAX-1];
    int    wr = 0;
    int    rd = 0;
    int    g_prev = UNITY;
    int    g_mid = UNITY;
    int    mid_edge = 0;
    string mid_tag = "";
    bit    primed = 0;

    int checks = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_fails = 0;
    bit timed_out = 0;

    function automatic int isqrt(int s);
        int r = 0;
        while ((r + 1) * (r + 1) <= s) r++;
        return r;
    endfunction

    function automatic int model_gain(int i, int q, int t);
        int e = isqrt(i * i + q * q);
        if (e > t) return (t * UNITY) / e;
        return UNITY;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic drive(int i, int q, int t, int t_next, string tag);
        int g;
        @(negedge clk);
        in_i     = DW'(i);
        in_q     = DW'(q);
        th       = DW'(t);
        in_valid = 1'b1;
        g = model_gain(i, q, t);
        if (primed) begin
            exp_arr[wr]  = ((g_mid < g_prev) && (g_mid <= g)) ? UNITY - g_mid : 0;
            edge_arr[wr] = mid_edge;
            tag_arr[wr]  = mid_tag;
            wr++;
        end
        g_prev   = g_mid;
        g_mid    = g;
        mid_edge = cyc + 1;
        mid_tag  = tag;
        primed   = 1;
        @(negedge clk);
        in_valid = 1'b0;
        th       = DW'(t_next);
        repeat (SLOT - 2) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                mon_checks++;
                mon_fails++;
                $display("FAIL R7 unexpected output actual=%0d expected=none", out_v);
            end else begin
                mon_checks += 2;
                if (int'(out_v) != exp_arr[rd]) begin
                    mon_fails++;
                    $display("FAIL %s sample %0d actual=%0d expected=%0d",
                             tag_arr[rd], rd, out_v, exp_arr[rd]);
                end
                if (cyc - edge_arr[rd] != LAT) begin
                    mon_fails++;
                    $display("FAIL R7 latency sample %0d actual=%0d expected=%0d",
                             rd, cyc - edge_arr[rd], LAT);
                end
            end
            rd++;
        end
    end

    task automatic run_all();
        int ths[5] = '{20, 0, 31, 45, 63};
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_v == '0, "R1 in reset", int'(out_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_v == '0, "R1 after reset", int'(out_v), 0);
        // R9: threshold changes one clock after the strobe of the clipping sample
        drive(1, 0, 10, 10, "R9");
        drive(30, 0, 10, 40, "R9 R3");
        drive(1, 0, 40, 40, "R9");
        // R5: flat run of equal clipped gains at th=20, envelope 30
        drive(5, 0, 20, 20, "R5");
        drive(30, 0, 20, 20, "R5 R3");
        drive(0, 30, 20, 20, "R5 R6");
        drive(-30, 0, 20, 20, "R5 R6");
        drive(5, 0, 20, 20, "R5");
        // exhaustive I/Q sweeps at several thresholds
        foreach (ths[k]) begin
            string tg;
            tg = (ths[k] >= 45) ? "R8" : "R2 R3 R4 R6";
            for (int i = -32; i < 32; i++) begin
                for (int q = -32; q < 32; q++) begin
                    drive(i, q, ths[k], ths[k], tg);
                end
            end
        end
        repeat (4 * LAT) @(negedge clk);
        check(rd == wr, "R7 output count", rd, wr);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        end
        $display("%0d/%0d checks passed",
                 (checks + mon_checks) - (fails + mon_fails), checks + mon_checks);
        $finish;
    end

endmodule